// File: doc/BRIEF.md
# PLL Control and Bandwidth Register Slice

This block is the register slice that software uses to set up a clock generator's phase-locked loop. A control register holds the loop enable, a two-bit VCO range exponent and a sticky flag that records an attempt to program the illegal exponent. A bandwidth register selects automatic or manual bandwidth control. It shows the loop's lock status. Its acquisition bit serves two purposes: in manual mode it is a software-forced acquisition request, and in automatic mode it reports acquisition or tracking status from hardware.

Access is through a plain single-cycle register bus. A write takes effect on the clock edge at which `bus_wr_en` is high. Reads are combinational from `bus_addr`. The bus has no valid/ready pair because every access completes in its own cycle and the block never applies back-pressure. The lock and acquisition status lines come from the PLL core and may be asynchronous, so each passes through a two-flop synchronizer. The block drives the enable, the decoded range multiplier, the bandwidth mode and the forced-acquisition request to the core.

Top module: `pllctl_regs`

## Requirements
- R1: The range field (control register bits 1:0) decodes onto `vco_mult_o` as 00→1, 01→2 and 10→4.
- R2: A control write of range 11 while the enable is clear leaves the range unchanged and sets the illegal-setting flag (control bit 4).
- R3: Writing 1 to control bit 4 clears the flag. If the same write also carries range 11 with the enable clear, the set wins.
- R4: Control bit 5 is the read/write enable and drives `pll_en_o`. While the stored enable is 1, range writes are ignored and raise no flag.
- R5: A control write that changes both enable and range gates the range update with the enable value held before that write.
- R6: Reset clears enable, range, flag, mode and the stored acquisition bit. Both registers then read 0 and `vco_mult_o` reads 1.
- R7: The bandwidth register at address 0x37 holds mode in bit 7 (1 = automatic), lock in bit 6 and acquisition in bit 5. Bits 4:0 read 0. The control register sits at 0x36.
- R8: Bandwidth bit 6 is read-only and reflects the synchronized lock input. Writes to it have no effect.
- R9: In automatic mode, bit 5 reads the synchronized acquisition input. Writes to bit 5 (gated by the mode held before the write) do not change the stored value. `force_acq_o` is 0.
- R10: In manual mode, bit 5 reads the stored software value, and `force_acq_o` equals it.
- R11: A status input change sampled at one clock edge becomes visible in the bandwidth register after the following edge.
- R12: Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr_en | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pll_lock_i | input | 1 | Lock status from PLL core (asynchronous) |
| pll_acq_i | input | 1 | Acquisition (1) / tracking (0) status from core |
| pll_en_o | output | 1 | PLL enable |
| vco_mult_o | output | 3 | Decoded VCO range multiplier (1, 2 or 4) |
| bw_auto_o | output | 1 | 1 = automatic bandwidth control |
| force_acq_o | output | 1 | Manual-mode forced acquisition request |

## Verification
The state is small enough that any corruption reaches the ports within one cycle. A wrong range or a range that slips through the enable lock shows at once on `vco_mult_o`. A flag or mode error shows on the next read of its register. A synchronizer of the wrong depth shifts the status bits by one cycle and is caught by a per-cycle comparison against a delay queue. The acquisition bit's dual role is only visible across mode switches, so the stored manual value is read back after a round trip through automatic mode.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;
  localparam int REG_W       = 8;
  localparam int CTL_EN_BIT  = 5;
  localparam int CTL_BAD_BIT = 4;
  localparam int CTL_RNG_LSB = 0;
  localparam int BW_AUTO_BIT = 7;
  localparam int BW_LOCK_BIT = 6;
  localparam int BW_ACQ_BIT  = 5;
  localparam int MULT_W      = 3;

  typedef enum logic [1:0] {
    RNG_X1  = 2'b00,
    RNG_X2  = 2'b01,
    RNG_X4  = 2'b10,
    RNG_BAD = 2'b11
  } vco_rng_e;

  function automatic logic [MULT_W-1:0] rng_to_mult(vco_rng_e r);
    logic [MULT_W-1:0] m;
    case (r)
      RNG_X1:  m = 3'd1;
      RNG_X2:  m = 3'd2;
      RNG_X4:  m = 3'd4;
      default: m = 3'd1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pllctl_sync.sv
module pllctl_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pllctl_ctrl_reg.sv
module pllctl_ctrl_reg
  import pllctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  output logic             en_o,
  output vco_rng_e         rng_o,
  output logic             bad_o
);
  logic     en_q, en_d, bad_q, bad_d;
  vco_rng_e rng_q, rng_d, rng_wr;

  assign rng_wr = vco_rng_e'(wr_data[CTL_RNG_LSB +: 2]);

  always_comb begin
    en_d  = en_q;
    rng_d = rng_q;
    bad_d = bad_q;
    if (wr_stb) begin
      if (wr_data[CTL_BAD_BIT]) bad_d = 1'b0;
      if (!en_q) begin
        if (rng_wr == RNG_BAD) bad_d = 1'b1;
        else                   rng_d = rng_wr;
      end
      en_d = wr_data[CTL_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rng_q <= RNG_X1;
      bad_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      rng_q <= rng_d;
      bad_q <= bad_d;
    end
  end

  assign en_o  = en_q;
  assign rng_o = rng_q;
  assign bad_o = bad_q;
endmodule

// File: rtl/pllctl_bw_reg.sv
module pllctl_bw_reg
  import pllctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [REG_W-1:0] wr_data,
  input  logic             lock_s,
  input  logic             acq_s,
  output logic             auto_o,
  output logic             force_acq_o,
  output logic [REG_W-1:0] rd_o
);
  logic auto_q, auto_d, acq_sw_q, acq_sw_d;

  always_comb begin
    auto_d   = auto_q;
    acq_sw_d = acq_sw_q;
    if (wr_stb) begin
      if (!auto_q) acq_sw_d = wr_data[BW_ACQ_BIT];
      auto_d = wr_data[BW_AUTO_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q   <= 1'b0;
      acq_sw_q <= 1'b0;
    end else begin
      auto_q   <= auto_d;
      acq_sw_q <= acq_sw_d;
    end
  end

  always_comb begin
    rd_o              = '0;
    rd_o[BW_AUTO_BIT] = auto_q;
    rd_o[BW_LOCK_BIT] = lock_s;
    rd_o[BW_ACQ_BIT]  = auto_q ? acq_s : acq_sw_q;
  end

  assign auto_o      = auto_q;
  assign force_acq_o = !auto_q && acq_sw_q;
endmodule

// File: rtl/pllctl_regs.sv
module pllctl_regs
  import pllctl_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h36,
  parameter logic [ADDR_W-1:0] BW_ADDR   = 8'h37,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              pll_lock_i,
  input  logic              pll_acq_i,
  output logic              pll_en_o,
  output logic [2:0]        vco_mult_o,
  output logic              bw_auto_o,
  output logic              force_acq_o
);
  localparam int STAT_W = 2;

  logic              sel_ctrl, sel_bw;
  logic [STAT_W-1:0] stat_sync;
  logic              bad_flag, en_q;
  vco_rng_e          rng_q;
  logic [REG_W-1:0]  ctrl_rd, bw_rd;

  assign sel_ctrl = (bus_addr == CTRL_ADDR);
  assign sel_bw   = (bus_addr == BW_ADDR);

  pllctl_sync #(.WIDTH(STAT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({pll_acq_i, pll_lock_i}),
    .sync_o  (stat_sync)
  );

  pllctl_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (bus_wr_en && sel_ctrl),
    .wr_data (bus_wdata),
    .en_o    (en_q),
    .rng_o   (rng_q),
    .bad_o   (bad_flag)
  );

  pllctl_bw_reg u_bw (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (bus_wr_en && sel_bw),
    .wr_data     (bus_wdata),
    .lock_s      (stat_sync[0]),
    .acq_s       (stat_sync[1]),
    .auto_o      (bw_auto_o),
    .force_acq_o (force_acq_o),
    .rd_o        (bw_rd)
  );

  always_comb begin
    ctrl_rd                        = '0;
    ctrl_rd[CTL_EN_BIT]            = en_q;
    ctrl_rd[CTL_BAD_BIT]           = bad_flag;
    ctrl_rd[CTL_RNG_LSB +: 2]      = rng_q;
  end

  always_comb begin
    if (sel_ctrl)    bus_rdata = ctrl_rd;
    else if (sel_bw) bus_rdata = bw_rd;
    else             bus_rdata = '0;
  end

  assign pll_en_o   = en_q;
  assign vco_mult_o = rng_to_mult(rng_q);
endmodule

// File: rtl/pllctl_regs_chk.sv
module pllctl_regs_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h36,
  parameter logic [ADDR_W-1:0] BW_ADDR   = 8'h37
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              pll_en_o,
  input logic [2:0]        vco_mult_o,
  input logic              bw_auto_o,
  input logic              force_acq_o,
  input logic              bad_flag
);
  p_mult_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vco_mult_o) == 1);

  p_bad_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == CTRL_ADDR && bus_wdata[1:0] == 2'b11 && !pll_en_o)
      |=> (bad_flag && $stable(vco_mult_o)));

  p_range_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en_o |=> $stable(vco_mult_o));

  p_en_written_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == CTRL_ADDR) |=> (pll_en_o == $past(bus_wdata[5])));

  p_bw_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == BW_ADDR) |-> (bus_rdata[4:0] == 5'd0));

  p_auto_noforce_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bw_auto_o |-> !force_acq_o);

  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != CTRL_ADDR && bus_addr != BW_ADDR) |-> (bus_rdata == 8'd0));
endmodule

bind pllctl_regs pllctl_regs_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .BW_ADDR(BW_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_en_o(pll_en_o),
  .vco_mult_o(vco_mult_o), .bw_auto_o(bw_auto_o), .force_acq_o(force_acq_o),
  .bad_flag(bad_flag)
);

// File: tb/sim_pllctl_regs.sv
`timescale 1ns/1ps
module sim_pllctl_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pll_lock_i = 1'b0, pll_acq_i = 1'b0;
  logic       pll_en_o, bw_auto_o, force_acq_o;
  logic [2:0] vco_mult_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pllctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_lock_i(pll_lock_i),
    .pll_acq_i(pll_acq_i), .pll_en_o(pll_en_o), .vco_mult_o(vco_mult_o),
    .bw_auto_o(bw_auto_o), .force_acq_o(force_acq_o)
  );

  // behavioural reference
  bit m_en, m_bad, m_auto, m_acq;
  int m_rng;
  bit lock_hist[$], acq_hist[$];

  function automatic bit vis(bit h[$]);
    return (h.size() == 2) ? h[0] : 1'b0;
  endfunction

  function automatic int ref_read(int a);
    if (a == 'h36) return (m_en << 5) | (m_bad << 4) | m_rng;
    if (a == 'h37) return (m_auto << 7) | (vis(lock_hist) << 6) |
                          ((m_auto ? vis(acq_hist) : m_acq) << 5);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_bad = 0; m_auto = 0; m_acq = 0; m_rng = 0;
      lock_hist.delete(); acq_hist.delete();
    end else begin
      lock_hist.push_back(pll_lock_i); acq_hist.push_back(pll_acq_i);
      if (lock_hist.size() > 2) void'(lock_hist.pop_front());
      if (acq_hist.size() > 2) void'(acq_hist.pop_front());
      if (bus_wr_en && bus_addr == 8'h36) begin
        if (bus_wdata[4]) m_bad = 0;
        if (!m_en) begin
          if (bus_wdata[1:0] == 2'b11) m_bad = 1;
          else m_rng = bus_wdata[1:0];
        end
        m_en = bus_wdata[5];
      end
      if (bus_wr_en && bus_addr == 8'h37) begin
        if (!m_auto) m_acq = bus_wdata[5];
        m_auto = bus_wdata[7];
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) if (!done) begin
    chk(pll_en_o == m_en, "R4 pll_en", pll_en_o, m_en);
    chk(vco_mult_o == (3'd1 << m_rng), "R1 mult", vco_mult_o, 1 << m_rng);
    chk(bw_auto_o == m_auto, "R7 auto", bw_auto_o, m_auto);
    chk(force_acq_o == (!m_auto && m_acq), "R10 force", force_acq_o, !m_auto && m_acq);
    chk(bus_rdata == ref_read(bus_addr), "R7 rdata", bus_rdata, ref_read(bus_addr));
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(posedge clk); #2;
    bus_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input int exp, input string tag);
    @(posedge clk); #2;
    bus_addr = a; bus_wr_en = 1'b0;
    @(negedge clk);
    chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R6 reset state
    rd_chk(8'h36, 'h00, "R6 ctrl after reset");
    rd_chk(8'h37, 'h00, "R6 bw after reset");
    chk(vco_mult_o == 3'd1, "R6 mult after reset", vco_mult_o, 1);
    // R1 decode
    wr(8'h36, 8'h01); chk(vco_mult_o == 3'd2, "R1 x2", vco_mult_o, 2);
    wr(8'h36, 8'h02); chk(vco_mult_o == 3'd4, "R1 x4", vco_mult_o, 4);
    wr(8'h36, 8'h00); chk(vco_mult_o == 3'd1, "R1 x1", vco_mult_o, 1);
    // R2 illegal keeps value
    wr(8'h36, 8'h02); wr(8'h36, 8'h03);
    rd_chk(8'h36, 'h12, "R2 illegal kept + flag");
    // R3 clear, and set wins
    wr(8'h36, 8'h12); rd_chk(8'h36, 'h02, "R3 w1c");
    wr(8'h36, 8'h03); wr(8'h36, 8'h13);
    rd_chk(8'h36, 'h12, "R3 set wins");
    wr(8'h36, 8'h10); rd_chk(8'h36, 'h00, "R3 cleared");
    // R5 same-access enable and range
    wr(8'h36, 8'h21); rd_chk(8'h36, 'h21, "R5 old enable gates");
    chk(pll_en_o == 1'b1, "R4 enable out", pll_en_o, 1);
    // R4 locked while enabled
    wr(8'h36, 8'h22); rd_chk(8'h36, 'h21, "R4 range locked");
    wr(8'h36, 8'h23); rd_chk(8'h36, 'h21, "R4 no flag when locked");
    wr(8'h36, 8'h02); rd_chk(8'h36, 'h01, "R5 disable keeps range");
    wr(8'h36, 8'h02); chk(vco_mult_o == 3'd4, "R4 unlocked again", vco_mult_o, 4);
    // R10 manual acquisition
    wr(8'h37, 8'h20); rd_chk(8'h37, 'h20, "R10 manual acq read");
    chk(force_acq_o == 1'b1, "R10 force out", force_acq_o, 1);
    // R8 lock read-only
    wr(8'h37, 8'h60); rd_chk(8'h37, 'h20, "R8 lock not writable");
    pll_lock_i = 1'b1; repeat (3) @(posedge clk);
    rd_chk(8'h37, 'h60, "R8 lock follows input");
    // R9 automatic
    wr(8'h37, 8'hA0); rd_chk(8'h37, 'hC0, "R9 auto shows status");
    chk(force_acq_o == 1'b0, "R9 no force in auto", force_acq_o, 0);
    wr(8'h37, 8'h80);
    // R11 synchronizer latency
    @(posedge clk); #2; pll_acq_i = 1'b1; bus_addr = 8'h37;
    @(negedge clk); chk(bus_rdata[5] == 1'b0, "R11 before edges", bus_rdata[5], 0);
    @(negedge clk); chk(bus_rdata[5] == 1'b0, "R11 after one edge", bus_rdata[5], 0);
    @(negedge clk); chk(bus_rdata[5] == 1'b1, "R11 after two edges", bus_rdata[5], 1);
    pll_acq_i = 1'b0;
    // R9 write ignored in auto: stored value survives
    wr(8'h37, 8'h00); rd_chk(8'h37, 'h60, "R9 stored acq kept");
    chk(force_acq_o == 1'b1, "R9 force restored", force_acq_o, 1);
    // R12 unmapped
    wr(8'h10, 8'hFF); rd_chk(8'h10, 'h00, "R12 unmapped read");
    rd_chk(8'h36, 'h02, "R12 ctrl untouched");
    rd_chk(8'h37, 'h60, "R12 bw untouched");
    // mixed traffic, compared every cycle
    for (int i = 0; i < 400; i++) begin
      @(posedge clk); #2;
      bus_addr  = 8'h35 + 8'($urandom_range(0, 3));
      bus_wdata = 8'($urandom);
      bus_wr_en = 1'($urandom);
      pll_lock_i = 1'($urandom);
      pll_acq_i  = 1'($urandom);
    end
    @(posedge clk); #2; bus_wr_en = 1'b0;
    // R6 reset mid-run
    wr(8'h36, 8'h22); wr(8'h37, 8'h20);
    pll_lock_i = 1'b0; pll_acq_i = 1'b0;
    rst_n = 1'b0; #1;
    chk(pll_en_o == 1'b0 && vco_mult_o == 3'd1, "R6 reset clears ctrl",
        {pll_en_o, vco_mult_o}, 1);
    chk(bw_auto_o == 1'b0 && force_acq_o == 1'b0, "R6 reset clears bw",
        {bw_auto_o, force_acq_o}, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    rd_chk(8'h37, 'h00, "R6 bw reads zero");
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule